// File: doc/BRIEF.md
# Endpoint Configuration and Stall Control Register Set

This block holds the configuration registers of a small USB device controller's endpoints. Software first writes an endpoint number into a select register. The per-endpoint registers (enable and stall control, type and direction, size and allocation, and status) then read and write the copy that belongs to the selected endpoint. The block also holds two global registers: a general controller register and a device control register with a detach bit.

Writing the second configuration register has side effects. It sets configuration-OK from the allocate bit. In the next cycle it also sends a one-cycle preload strobe to the buffer controller, which sets or clears that endpoint's transfer flags according to the endpoint's type and direction. The buffer controller sends events back into the status register of a named endpoint: overflow, underflow and data-toggle updates. Enable and stall state come out as one bit per endpoint.

All ports are plain control and status pins, and none uses back-pressure. The register port performs a write whenever `reg_wr` is high at a clock edge. It returns the addressed register on `reg_rdata` combinationally.

Top module: `ep_cfg_regs`

## Requirements
- R1: After reset, the general register (address 0) reads 0x20, the device register (address 1) reads 0x01 with its detach bit 0 set, the select register (address 2) reads 0, and every endpoint register reads 0.
- R2: Addresses 3 (control), 4 (config A), 5 (config B) and 6 (status) act on the endpoint named by the select register. Each endpoint keeps its own values.
- R3: A write to the select register with a value of N_EP or more is ignored, and the previous selection stays.
- R4: In the control register, bit 0 is the endpoint enable and reads back in bit 0. Writing 1 to bit 4 clears the stall request and writing 1 to bit 5 sets it; when both are 1, set wins. The stall request reads back in bit 5, and all other bits read 0. `ep_en` and `ep_stall` show these bits for every endpoint.
- R5: Config A keeps direction in bit 0 (1 = IN) and type in bits 7:6 (0 = control). Other bits read 0. Any write to config A clears configuration-OK.
- R6: Config B keeps allocate in bit 1, bank count in bits 3:2 and size code in bits 6:4, with other bits reading 0. A write to config B sets configuration-OK equal to written bit 1.
- R7: One cycle after a config B write, `pl_stb` pulses for one cycle with `pl_ep` equal to the selected endpoint. For a control type, only `pl_txini` is set. For another type with direction IN, `pl_txini`, `pl_rwal` and `pl_fifocon` are set. For another type with direction OUT, only `pl_rxout_clr` is set. Outside the pulse, all strobes are 0.
- R8: The status register reads configuration-OK in bit 7, overflow in bit 6, underflow in bit 5 and the data toggle in bits 3:2. A software write only clears overflow or underflow where the written bit is 0; all other bits are kept.
- R9: `ovf_set` or `unf_set` sets the overflow or underflow bit of endpoint `ev_ep`. When a software status write to the same endpoint falls in the same cycle, the event wins.
- R10: `tog_we` loads `tog_val` into the data-toggle field of endpoint `ev_ep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| ev_ep | input | EPW | Endpoint targeted by buffer events |
| ovf_set | input | 1 | Overflow event |
| unf_set | input | 1 | Underflow event |
| tog_we | input | 1 | Data-toggle update strobe |
| tog_val | input | 2 | New data-toggle value |
| ep_en | output | N_EP | Enable per endpoint |
| ep_stall | output | N_EP | Stall request per endpoint |
| pl_stb | output | 1 | Flag preload strobe |
| pl_ep | output | EPW | Endpoint of the preload |
| pl_txini | output | 1 | Set transmit-ready |
| pl_rwal | output | 1 | Set read/write-allowed |
| pl_fifocon | output | 1 | Set FIFO-control |
| pl_rxout_clr | output | 1 | Clear received-OUT |

## Verification
The bench checks that set wins when both stall bits are written together; a design that cleared last would drop a stall that software requested. It writes select values of N_EP and above, which a design that does not check the range would accept, sending later accesses to a missing endpoint. It sends an overflow event in the same cycle as a clearing status write, which a design with the wrong priority would lose. It also checks the preload strobe of each type and direction, where a design that used the newly written data or the wrong endpoint's type would set the wrong flags.

// File: rtl/ep_cfg_pkg.sv
package ep_cfg_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_GLOB = 3'd0;
  localparam logic [AW-1:0] A_DEV  = 3'd1;
  localparam logic [AW-1:0] A_SEL  = 3'd2;
  localparam logic [AW-1:0] A_CTRL = 3'd3;
  localparam logic [AW-1:0] A_CFGA = 3'd4;
  localparam logic [AW-1:0] A_CFGB = 3'd5;
  localparam logic [AW-1:0] A_STAT = 3'd6;
  localparam logic [7:0] GLOB_RST = 8'h20;
  localparam logic [7:0] DEV_RST  = 8'h01;

  typedef enum logic [1:0] {
    T_CONTROL = 2'd0, T_ISO = 2'd1, T_BULK = 2'd2, T_INTR = 2'd3
  } ep_type_e;

  typedef struct packed {
    logic txini;
    logic rwal;
    logic fifocon;
    logic rxout_clr;
  } preload_t;
endpackage

// File: rtl/ep_cfg_slot.sv
module ep_cfg_slot
  import ep_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_cfga,
  input  logic       wr_cfgb,
  input  logic       wr_stat,
  input  logic [7:0] wdata,
  input  logic       ev_ovf,
  input  logic       ev_unf,
  input  logic       ev_tog,
  input  logic [1:0] tog_val,
  output logic [7:0] ctrl_rd,
  output logic [7:0] cfga_rd,
  output logic [7:0] cfgb_rd,
  output logic [7:0] stat_rd,
  output logic       en,
  output logic       stall,
  output ep_type_e   ep_type,
  output logic       ep_dir
);
  logic [5:0] cfgb_q;
  logic       cfgok_q, ovf_q, unf_q;
  logic [1:0] tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      stall <= 1'b0;
      ep_type <= T_CONTROL;
      ep_dir <= 1'b0;
      cfgb_q <= '0;
      cfgok_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      tog_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en <= wdata[0];
        if (wdata[5]) stall <= 1'b1;
        else if (wdata[4]) stall <= 1'b0;
      end
      if (wr_cfga) begin
        ep_type <= ep_type_e'(wdata[7:6]);
        ep_dir <= wdata[0];
        cfgok_q <= 1'b0;
      end
      if (wr_cfgb) begin
        cfgb_q <= wdata[6:1];
        cfgok_q <= wdata[1];
      end
      if (ev_ovf) ovf_q <= 1'b1;
      else if (wr_stat) ovf_q <= ovf_q & wdata[6];
      if (ev_unf) unf_q <= 1'b1;
      else if (wr_stat) unf_q <= unf_q & wdata[5];
      if (ev_tog) tog_q <= tog_val;
    end
  end

  assign ctrl_rd = {2'b00, stall, 4'b0000, en};
  assign cfga_rd = {ep_type, 5'b00000, ep_dir};
  assign cfgb_rd = {1'b0, cfgb_q, 1'b0};
  assign stat_rd = {cfgok_q, ovf_q, unf_q, 1'b0, tog_q, 2'b00};
endmodule

// File: rtl/ep_cfg_preload.sv
module ep_cfg_preload
  import ep_cfg_pkg::*;
#(
  parameter int EPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic [EPW-1:0] ep_in,
  input  ep_type_e       ep_type,
  input  logic           ep_dir,
  output logic           stb,
  output logic [EPW-1:0] ep_out,
  output preload_t       flags
);
  preload_t nxt;

  always_comb begin
    nxt = '0;
    if (ep_type == T_CONTROL) begin
      nxt.txini = 1'b1;
    end else if (ep_dir) begin
      nxt.txini = 1'b1;
      nxt.rwal = 1'b1;
      nxt.fifocon = 1'b1;
    end else begin
      nxt.rxout_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb <= 1'b0;
      ep_out <= '0;
      flags <= '0;
    end else begin
      stb <= fire;
      ep_out <= fire ? ep_in : '0;
      flags <= fire ? nxt : '0;
    end
  end
endmodule

// File: rtl/ep_cfg_regs.sv
module ep_cfg_regs
  import ep_cfg_pkg::*;
#(
  parameter int N_EP = 5,
  localparam int EPW = (N_EP > 1) ? $clog2(N_EP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [EPW-1:0]  ev_ep,
  input  logic            ovf_set,
  input  logic            unf_set,
  input  logic            tog_we,
  input  logic [1:0]      tog_val,
  output logic [N_EP-1:0] ep_en,
  output logic [N_EP-1:0] ep_stall,
  output logic            pl_stb,
  output logic [EPW-1:0]  pl_ep,
  output logic            pl_txini,
  output logic            pl_rwal,
  output logic            pl_fifocon,
  output logic            pl_rxout_clr
);
  logic [7:0]     glob_q, dev_q;
  logic [EPW-1:0] sel_q;
  logic           sel_ok;

  logic [7:0] ctrl_rd [N_EP];
  logic [7:0] cfga_rd [N_EP];
  logic [7:0] cfgb_rd [N_EP];
  logic [7:0] stat_rd [N_EP];
  ep_type_e   typ [N_EP];
  logic       dir [N_EP];
  preload_t   pl_flags;

  assign sel_ok = int'(reg_wdata) < N_EP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= GLOB_RST;
      dev_q <= DEV_RST;
      sel_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_GLOB) glob_q <= reg_wdata;
      if (reg_addr == A_DEV) dev_q <= reg_wdata;
      if (reg_addr == A_SEL && sel_ok) sel_q <= reg_wdata[EPW-1:0];
    end
  end

  for (genvar i = 0; i < N_EP; i++) begin : g_ep
    logic here, ev_here;
    assign here = reg_wr && (int'(sel_q) == i);
    assign ev_here = (int'(ev_ep) == i);
    ep_cfg_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(here && reg_addr == A_CTRL),
      .wr_cfga(here && reg_addr == A_CFGA),
      .wr_cfgb(here && reg_addr == A_CFGB),
      .wr_stat(here && reg_addr == A_STAT),
      .wdata(reg_wdata),
      .ev_ovf(ev_here && ovf_set),
      .ev_unf(ev_here && unf_set),
      .ev_tog(ev_here && tog_we),
      .tog_val(tog_val),
      .ctrl_rd(ctrl_rd[i]), .cfga_rd(cfga_rd[i]),
      .cfgb_rd(cfgb_rd[i]), .stat_rd(stat_rd[i]),
      .en(ep_en[i]), .stall(ep_stall[i]),
      .ep_type(typ[i]), .ep_dir(dir[i])
    );
  end

  ep_cfg_preload #(.EPW(EPW)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .fire(reg_wr && reg_addr == A_CFGB),
    .ep_in(sel_q),
    .ep_type(typ[sel_q]),
    .ep_dir(dir[sel_q]),
    .stb(pl_stb),
    .ep_out(pl_ep),
    .flags(pl_flags)
  );

  assign pl_txini = pl_flags.txini;
  assign pl_rwal = pl_flags.rwal;
  assign pl_fifocon = pl_flags.fifocon;
  assign pl_rxout_clr = pl_flags.rxout_clr;

  always_comb begin
    case (reg_addr)
      A_GLOB:  reg_rdata = glob_q;
      A_DEV:   reg_rdata = dev_q;
      A_SEL:   reg_rdata = 8'(sel_q);
      A_CTRL:  reg_rdata = ctrl_rd[sel_q];
      A_CFGA:  reg_rdata = cfga_rd[sel_q];
      A_CFGB:  reg_rdata = cfgb_rd[sel_q];
      A_STAT:  reg_rdata = stat_rd[sel_q];
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/ep_cfg_regs_chk.sv
module ep_cfg_regs_chk
  import ep_cfg_pkg::*;
#(
  parameter int N_EP = 5,
  parameter int EPW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [2:0]      reg_addr,
  input logic [7:0]      reg_wdata,
  input logic [EPW-1:0]  sel,
  input logic [N_EP-1:0] ep_stall,
  input logic            pl_stb,
  input logic            pl_txini,
  input logic            pl_rxout_clr
);
  // R7
  preload_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_stb |-> $past(reg_wr && reg_addr == A_CFGB));
  // R7
  preload_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pl_txini && pl_rxout_clr));
  // R4
  stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL && reg_wdata[5]) |=> ep_stall[$past(sel)]);
  // R4
  stall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL && reg_wdata[4] && !reg_wdata[5]) |=> !ep_stall[$past(sel)]);
  // R3
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel) < N_EP);
endmodule

bind ep_cfg_regs ep_cfg_regs_chk #(.N_EP(N_EP), .EPW(EPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sel(sel_q), .ep_stall(ep_stall),
  .pl_stb(pl_stb), .pl_txini(pl_txini), .pl_rxout_clr(pl_rxout_clr)
);

// File: tb/tb_ep_cfg_regs.sv
module tb_ep_cfg_regs;
  localparam int N = 5;
  localparam int EPW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [EPW-1:0] ev_ep = '0, pl_ep;
  logic ovf_set = 1'b0, unf_set = 1'b0, tog_we = 1'b0;
  logic [1:0] tog_val = '0;
  logic [N-1:0] ep_en, ep_stall;
  logic pl_stb, pl_txini, pl_rwal, pl_fifocon, pl_rxout_clr;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_glob, m_dev;
  int m_sel;
  logic m_en[N], m_stall[N], m_dir[N], m_ok[N], m_ovf[N], m_unf[N];
  logic [1:0] m_typ[N], m_tog[N];
  logic [5:0] m_b[N];

  always #2.5 clk = ~clk;

  ep_cfg_regs #(.N_EP(N)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(int a, int e);
    case (a)
      0: return m_glob;
      1: return m_dev;
      2: return 8'(m_sel);
      3: return {2'b00, m_stall[e], 4'b0, m_en[e]};
      4: return {m_typ[e], 5'b0, m_dir[e]};
      5: return {1'b0, m_b[e], 1'b0};
      6: return {m_ok[e], m_ovf[e], m_unf[e], 1'b0, m_tog[e], 2'b00};
      default: return 8'h00;
    endcase
  endfunction

  task automatic rd(int a, string req);
    reg_addr = 3'(a);
    #1;
    chk(req, reg_rdata, exp_reg(a, m_sel));
  endtask

  task automatic rd_all(string req);
    for (int a = 0; a < 7; a++) rd(a, req);
    for (int e = 0; e < N; e++) begin
      chk("R4 ep_en", ep_en[e], m_en[e]);
      chk("R4 ep_stall", ep_stall[e], m_stall[e]);
    end
  endtask

  // drive one write in the cycle starting now (at negedge); ev_* may be set by caller
  task automatic wr(int a, logic [7:0] d);
    logic [3:0] pl;
    int s;
    s = m_sel;
    reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (m_typ[s] == 2'd0) pl = 4'b1000;
    else if (m_dir[s]) pl = 4'b1110;
    else pl = 4'b0001;
    case (a)
      0: m_glob = d;
      1: m_dev = d;
      2: if (int'(d) < N) m_sel = int'(d);
      3: begin
        m_en[s] = d[0];
        if (d[5]) m_stall[s] = 1'b1; else if (d[4]) m_stall[s] = 1'b0;
      end
      4: begin m_typ[s] = d[7:6]; m_dir[s] = d[0]; m_ok[s] = 1'b0; end
      5: begin m_b[s] = d[6:1]; m_ok[s] = d[1]; end
      6: begin
        if (!(ovf_set && int'(ev_ep) == s)) m_ovf[s] = m_ovf[s] & d[6];
        if (!(unf_set && int'(ev_ep) == s)) m_unf[s] = m_unf[s] & d[5];
      end
      default: ;
    endcase
    if (ovf_set) m_ovf[ev_ep] = 1'b1;
    if (unf_set) m_unf[ev_ep] = 1'b1;
    if (tog_we) m_tog[ev_ep] = tog_val;
    ovf_set = 0; unf_set = 0; tog_we = 0;
    if (a == 5) begin
      chk("R7 stb", pl_stb, 1);
      chk("R7 ep", pl_ep, s);
      chk("R7 flags", {pl_txini, pl_rwal, pl_fifocon, pl_rxout_clr}, pl);
    end else begin
      chk("R7 idle", {pl_stb, pl_txini, pl_rwal, pl_fifocon, pl_rxout_clr}, 0);
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_glob = 8'h20; m_dev = 8'h01; m_sel = 0;
    for (int e = 0; e < N; e++) begin
      m_en[e] = 0; m_stall[e] = 0; m_dir[e] = 0; m_ok[e] = 0;
      m_ovf[e] = 0; m_unf[e] = 0; m_typ[e] = 0; m_tog[e] = 0; m_b[e] = 0;
    end
    #12; rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd_all("R1 reset");
    for (int e = 0; e < N; e++) begin
      wr(2, 8'(e));
      rd_all("R1 reset per ep");
    end
    // R3 out-of-range select ignored
    wr(2, 8'd2);
    wr(2, 8'(N));
    rd(2, "R3 sel kept");
    wr(2, 8'hFF);
    rd(2, "R3 sel kept ff");
    // R4 set wins when both bits written
    wr(3, 8'h31);
    rd(3, "R4 both set wins");
    wr(3, 8'h10);
    rd(3, "R4 clear");
    // R6/R5 cfgok from alloc then cleared by config A
    wr(5, 8'h7E);
    rd(6, "R6 cfgok set");
    wr(4, 8'h81);
    rd(6, "R5 cfgok cleared");
    // R7 each kind: control, IN bulk, OUT bulk
    wr(4, 8'h00); wr(5, 8'h02);
    wr(4, 8'h81); wr(5, 8'h02);
    wr(4, 8'h80); wr(5, 8'h02);
    // R9 event beats same-cycle clearing write
    ev_ep = 3'd2; ovf_set = 1; unf_set = 1;
    wr(6, 8'h00);
    rd(6, "R9 event wins");
    wr(6, 8'h40);
    rd(6, "R8 clear unf only");
    wr(6, 8'hFF);
    rd(6, "R8 write cannot set");
    // R10 toggle
    ev_ep = 3'd2; tog_val = 2'd3; tog_we = 1;
    wr(0, 8'h5A);
    rd(6, "R10 toggle");
    rd(0, "R1 glob rw");
    // R2 random traffic
    for (int it = 0; it < 600; it++) begin
      int a;
      logic [7:0] d;
      a = int'($urandom_range(0, 6));
      d = 8'($urandom);
      if (a == 2) d = 8'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) begin
        ev_ep = 3'($urandom_range(0, N - 1));
        ovf_set = 1'($urandom); unf_set = 1'($urandom);
        tog_we = 1'($urandom); tog_val = 2'($urandom);
      end
      wr(a, d);
      rd_all("R2 random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule